// File: doc/BRIEF.md
# DDR4 Rank Initialization Command Sequencer

This block generates the command stream that configures the DRAM devices of one registered DDR4 DIMM during bring-up. A start pulse captures the configuration: which ranks are fitted, which ranks use mirrored address wiring, a data-rate class flag, a long-ZQ-calibration enable and the values of the mode registers. The block then presents commands one at a time on a valid/ready interface. Each command carries its type (mode-register set or long ZQ calibration), the rank, the register side, bank group, bank, address and the number of idle cycles that must follow it.

The sequence is built from two nested loops. The outer loop walks the mode-register entries in ascending index order. The inner loop walks the fitted ranks in ascending order. Every command is sent twice: first for the A side of the register, then for the B side, where the B-side copy has selected address bits and all bank bits inverted. When calibration is enabled, a final phase sends a long ZQ calibration to each fitted rank in the same A-then-B pattern. After each accepted command the block stays quiet for that command's idle count. It pulses `done` when the last idle count has run out.

The controller is a four-state machine. `ST_IDLE` waits for start and either moves to `ST_ISSUE` (at least one rank is fitted) or to `ST_DONE` (no rank is fitted). `ST_ISSUE` holds the command until it is accepted, then moves to `ST_GAP`. `ST_GAP` counts the idle cycles. On expiry it moves to the B side, advances to the next rank, register or phase (back to `ST_ISSUE`), or moves to `ST_DONE` after the final command. `ST_DONE` lasts one cycle and returns to `ST_IDLE`.

Top module: `ddr4_rank_init_seq`

## Requirements
- R1: After reset, `cmd_valid` and `done` are low, and they stay low until a start pulse arrives.
- R2: Order of commands. Mode entries are sent in ascending index order. For each entry, every rank whose `rank_present` bit is set is visited in ascending order, and ranks with a clear bit are skipped. Each rank receives its A-side command (`cmd_side`=0) and then its B-side command (`cmd_side`=1).
- R3: A mode-register command of entry i has `cmd_zq`=0 and an A-side address equal to `mr_values[18*i+17:18*i]`, before any mirroring. Its A-side bank is i[1:0] and its bank group is {0, i[2]}. Its idle count is 8.
- R4: When `zq_en` was set at start, all mode-register commands are followed by one long ZQ calibration per fitted rank (`cmd_zq`=1). Its A-side address has only bit 10 set, and its bank and bank group are zero. When `zq_en` was clear, no command with `cmd_zq`=1 is sent.
- R5: The idle count of a ZQ calibration command is 597+1024=1621 when `fast_rate`=0 and 768+1024=1792 when `fast_rate`=1.
- R6: The B-side command equals the A-side command except for these inversions: address bits 3 to 9, 11, 13 and 17, both bank bits and both bank-group bits. Address bits 0 to 2, 10, 12 and 14 to 16 are unchanged.
- R7: When a rank's `mirror_rank` bit is set, its A-side command has these pairs exchanged: address bits 3/4, 5/6, 7/8 and 11/13, bank bits 0/1 and bank-group bits 0/1. The B side is derived from the mirrored A side.
- R8: After a command is accepted, `cmd_valid` stays low for exactly the accepted command's idle count, and the next command appears in the cycle after that. The first command appears in the cycle after the start pulse.
- R9: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid` and all command fields stay unchanged.
- R10: `done` is high for exactly one cycle, in the cycle after the last command's idle count expires. With no fitted rank, `done` is high in the cycle after the start pulse and no command is sent.
- R11: All configuration inputs are sampled only when a start pulse is accepted in `ST_IDLE`. A start pulse or a change of configuration during a run has no effect on the command stream or on `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, accepted only in `ST_IDLE` |
| rank_present | input | NUM_RANKS | Set bit marks a fitted rank |
| fast_rate | input | 1 | 1 when the data rate is 2133 MT/s or more |
| zq_en | input | 1 | Enables the long ZQ calibration phase |
| mirror_rank | input | NUM_RANKS | Set bit marks a rank with mirrored address wiring |
| mr_values | input | NUM_MR*18 | Mode-register values, entry i in bits [18i+17:18i] |
| cmd_valid | output | 1 | Command present |
| cmd_ready | input | 1 | Consumer accepts the command |
| cmd_zq | output | 1 | 0 = mode-register set, 1 = long ZQ calibration |
| cmd_side | output | 1 | 0 = A side, 1 = B side |
| cmd_rank | output | RANK_W | Target rank index |
| cmd_bg | output | 2 | Bank group |
| cmd_ba | output | 2 | Bank |
| cmd_addr | output | 18 | Address |
| cmd_idle | output | IDLE_W | Idle cycles required after this command |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench targets several corner cases, each tied to a specific fault:
- An empty rank mask. A design that still visits rank 0 emits commands; a design that never reaches `ST_DONE` hangs.
- Sparse masks and a mask holding only the top rank. These expose a next-rank search that wraps around or stops early.
- Each calibration setting and each rate class. These catch a ZQ phase that cannot be switched off, and a swapped or mis-summed idle count, which shows up as a gap one or more cycles wrong.
- Mirrored ranks combined with the B side, checking that mirroring is applied before inversion. Applying it in the other order, or inverting the wrong bit set, changes specific address bits.
- Restarts and configuration changes in the middle of a run. A design that re-samples its inputs produces a different stream or a second `done`.

// File: rtl/rinit_pkg.sv
package rinit_pkg;

    localparam int ADDR_W = 18;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_GAP,
        ST_DONE
    } seq_state_e;

    typedef enum logic {
        PH_MODE,
        PH_ZQ
    } seq_phase_e;

    typedef struct packed {
        logic [1:0]        bg;
        logic [1:0]        ba;
        logic [ADDR_W-1:0] addr;
    } dram_word_t;

    // Address bits that the register inverts on its B-side outputs.
    localparam logic [ADDR_W-1:0] B_SIDE_INV = 18'h22BF8;

    // Long ZQ calibration carries only A10 high.
    localparam logic [ADDR_W-1:0] ZQ_LONG_ADDR = 18'h00400;

endpackage

// File: rtl/rinit_rank_pick.sv
module rinit_rank_pick #(
    parameter int NUM_RANKS = 4,
    localparam int RANK_W = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1
) (
    input  logic [NUM_RANKS-1:0] present,
    input  logic [RANK_W:0]      from_idx,
    output logic                 found,
    output logic [RANK_W-1:0]    idx
);

    // Lowest fitted rank at or above from_idx.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NUM_RANKS - 1; i >= 0; i--) begin
            if (present[i] && (32'(i) >= 32'(from_idx))) begin
                found = 1'b1;
                idx   = RANK_W'(i);
            end
        end
    end

endmodule

// File: rtl/rinit_addr_xform.sv
module rinit_addr_xform
    import rinit_pkg::*;
(
    input  dram_word_t a_word,
    input  logic       mirror,
    input  logic       b_side,
    output dram_word_t w_out
);

    dram_word_t mirrored;

    always_comb begin
        mirrored = a_word;
        if (mirror) begin
            mirrored.addr[3]  = a_word.addr[4];
            mirrored.addr[4]  = a_word.addr[3];
            mirrored.addr[5]  = a_word.addr[6];
            mirrored.addr[6]  = a_word.addr[5];
            mirrored.addr[7]  = a_word.addr[8];
            mirrored.addr[8]  = a_word.addr[7];
            mirrored.addr[11] = a_word.addr[13];
            mirrored.addr[13] = a_word.addr[11];
            mirrored.ba       = {a_word.ba[0], a_word.ba[1]};
            mirrored.bg       = {a_word.bg[0], a_word.bg[1]};
        end
    end

    always_comb begin
        w_out = mirrored;
        if (b_side) begin
            w_out.addr = mirrored.addr ^ B_SIDE_INV;
            w_out.ba   = ~mirrored.ba;
            w_out.bg   = ~mirrored.bg;
        end
    end

endmodule

// File: rtl/rinit_gap_ctr.sv
module rinit_gap_ctr #(
    parameter int IDLE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [IDLE_W-1:0] load_val,
    output logic              expire
);

    logic [IDLE_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expire = (cnt_q == IDLE_W'(1));

    // R8
    gap_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (load_val != '0));

    // R8
    gap_no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (cnt_q == '0));

endmodule

// File: rtl/ddr4_rank_init_seq.sv
module ddr4_rank_init_seq
    import rinit_pkg::*;
#(
    parameter int NUM_RANKS  = 4,
    parameter int NUM_MR     = 7,
    parameter int IDLE_W     = 16,
    parameter int TMRD       = 8,
    parameter int TDLLK_SLOW = 597,
    parameter int TDLLK_FAST = 768,
    parameter int TZQINIT    = 1024,
    localparam int RANK_W    = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1,
    localparam int MR_W      = (NUM_MR > 1) ? $clog2(NUM_MR) : 1,
    localparam int MR_PACK_W = NUM_MR * ADDR_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [NUM_RANKS-1:0] rank_present,
    input  logic                 fast_rate,
    input  logic                 zq_en,
    input  logic [NUM_RANKS-1:0] mirror_rank,
    input  logic [MR_PACK_W-1:0] mr_values,
    output logic                 cmd_valid,
    input  logic                 cmd_ready,
    output logic                 cmd_zq,
    output logic                 cmd_side,
    output logic [RANK_W-1:0]    cmd_rank,
    output logic [1:0]           cmd_bg,
    output logic [1:0]           cmd_ba,
    output logic [ADDR_W-1:0]    cmd_addr,
    output logic [IDLE_W-1:0]    cmd_idle,
    output logic                 done
);

    localparam logic [IDLE_W-1:0] IDLE_MODE    = IDLE_W'(TMRD);
    localparam logic [IDLE_W-1:0] IDLE_ZQ_SLOW = IDLE_W'(TDLLK_SLOW + TZQINIT);
    localparam logic [IDLE_W-1:0] IDLE_ZQ_FAST = IDLE_W'(TDLLK_FAST + TZQINIT);
    localparam logic [MR_W-1:0]   LAST_MR      = MR_W'(NUM_MR - 1);

    // ---------------- state and captured configuration ----------------
    seq_state_e             state_q, state_d;
    seq_phase_e             phase_q, phase_d;
    logic [MR_W-1:0]        mr_q, mr_d;
    logic [RANK_W-1:0]      rank_q, rank_d;
    logic                   side_q, side_d;
    logic [NUM_RANKS-1:0]   mask_q, mirror_q;
    logic                   fast_q, zq_q;
    logic [MR_PACK_W-1:0]   mrv_q;
    logic                   capture;

    // ---------------- mode-register value table ----------------
    logic [ADDR_W-1:0] mr_tab [NUM_MR];

    for (genvar g = 0; g < NUM_MR; g++) begin : g_mr_tab
        assign mr_tab[g] = mrv_q[g*ADDR_W +: ADDR_W];
    end

    // ---------------- rank search ----------------
    logic [NUM_RANKS-1:0] first_src;
    logic                 first_found, next_found;
    logic [RANK_W-1:0]    first_idx, next_idx;
    logic [RANK_W:0]      next_from;

    assign first_src = (state_q == ST_IDLE) ? rank_present : mask_q;
    assign next_from = {1'b0, rank_q} + 1'b1;

    rinit_rank_pick #(.NUM_RANKS(NUM_RANKS)) u_first_pick (
        .present  (first_src),
        .from_idx ('0),
        .found    (first_found),
        .idx      (first_idx)
    );

    rinit_rank_pick #(.NUM_RANKS(NUM_RANKS)) u_next_pick (
        .present  (mask_q),
        .from_idx (next_from),
        .found    (next_found),
        .idx      (next_idx)
    );

    // ---------------- current command word ----------------
    dram_word_t        a_word, out_word;
    logic [IDLE_W-1:0] cur_idle;
    logic [31:0]       mr_num;

    always_comb begin
        mr_num = 32'(mr_q);
        if (phase_q == PH_MODE) begin
            a_word.addr = mr_tab[mr_q];
            a_word.ba   = mr_num[1:0];
            a_word.bg   = {1'b0, mr_num[2]};
            cur_idle    = IDLE_MODE;
        end else begin
            a_word.addr = ZQ_LONG_ADDR;
            a_word.ba   = 2'b00;
            a_word.bg   = 2'b00;
            cur_idle    = fast_q ? IDLE_ZQ_FAST : IDLE_ZQ_SLOW;
        end
    end

    rinit_addr_xform u_xform (
        .a_word (a_word),
        .mirror (mirror_q[rank_q]),
        .b_side (side_q),
        .w_out  (out_word)
    );

    // ---------------- idle gap counter ----------------
    logic gap_load, gap_expire;

    rinit_gap_ctr #(.IDLE_W(IDLE_W)) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (gap_load),
        .load_val (cur_idle),
        .expire   (gap_expire)
    );

    // ---------------- advance to the next rank / entry / phase ----------------
    logic       adv_last;
    seq_phase_e adv_phase;
    logic [MR_W-1:0]   adv_mr;
    logic [RANK_W-1:0] adv_rank;

    always_comb begin
        adv_last  = 1'b0;
        adv_phase = phase_q;
        adv_mr    = mr_q;
        adv_rank  = rank_q;
        if (next_found) begin
            adv_rank = next_idx;
        end else if (phase_q == PH_MODE && mr_q != LAST_MR) begin
            adv_mr   = mr_q + 1'b1;
            adv_rank = first_idx;
        end else if (phase_q == PH_MODE && zq_q) begin
            adv_phase = PH_ZQ;
            adv_rank  = first_idx;
        end else begin
            adv_last = 1'b1;
        end
    end

    // ---------------- next-state process ----------------
    always_comb begin
        state_d  = state_q;
        phase_d  = phase_q;
        mr_d     = mr_q;
        rank_d   = rank_q;
        side_d   = side_q;
        capture  = 1'b0;
        gap_load = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    capture = 1'b1;
                    phase_d = PH_MODE;
                    mr_d    = '0;
                    side_d  = 1'b0;
                    rank_d  = first_idx;
                    state_d = first_found ? ST_ISSUE : ST_DONE;
                end
            end
            ST_ISSUE: begin
                if (cmd_ready) begin
                    gap_load = 1'b1;
                    state_d  = ST_GAP;
                end
            end
            ST_GAP: begin
                if (gap_expire) begin
                    if (!side_q) begin
                        side_d  = 1'b1;
                        state_d = ST_ISSUE;
                    end else if (adv_last) begin
                        state_d = ST_DONE;
                    end else begin
                        side_d  = 1'b0;
                        phase_d = adv_phase;
                        mr_d    = adv_mr;
                        rank_d  = adv_rank;
                        state_d = ST_ISSUE;
                    end
                end
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // ---------------- state register process ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            phase_q  <= PH_MODE;
            mr_q     <= '0;
            rank_q   <= '0;
            side_q   <= 1'b0;
            mask_q   <= '0;
            mirror_q <= '0;
            fast_q   <= 1'b0;
            zq_q     <= 1'b0;
            mrv_q    <= '0;
        end else begin
            state_q <= state_d;
            phase_q <= phase_d;
            mr_q    <= mr_d;
            rank_q  <= rank_d;
            side_q  <= side_d;
            if (capture) begin
                mask_q   <= rank_present;
                mirror_q <= mirror_rank;
                fast_q   <= fast_rate;
                zq_q     <= zq_en;
                mrv_q    <= mr_values;
            end
        end
    end

    // ---------------- output process ----------------
    always_comb begin
        cmd_valid = (state_q == ST_ISSUE);
        done      = (state_q == ST_DONE);
        cmd_zq    = (phase_q == PH_ZQ);
        cmd_side  = side_q;
        cmd_rank  = rank_q;
        cmd_bg    = out_word.bg;
        cmd_ba    = out_word.ba;
        cmd_addr  = out_word.addr;
        cmd_idle  = cur_idle;
    end

    // ---------------- assertions ----------------
    // R9
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_addr) && $stable(cmd_rank)
                                       && $stable(cmd_side) && $stable(cmd_zq)));

    // R8
    gap_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> !cmd_valid);

    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !cmd_valid));

    // R2
    rank_fitted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> mask_q[cmd_rank]);

    // R4
    zq_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_zq) |-> (zq_q && cmd_addr[10]));

    // R11
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> ($stable(mask_q) && $stable(mrv_q) && $stable(zq_q)));

endmodule

// File: tb/sim_ddr4_rank_init_seq.sv
`timescale 1ns/1ps
module sim_ddr4_rank_init_seq;

    localparam int NR  = 4;
    localparam int NMR = 7;
    localparam int AW  = 18;
    localparam int IW  = 16;
    localparam int RW  = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [NR-1:0]     rank_present = '0;
    logic              fast_rate = 1'b0;
    logic              zq_en = 1'b0;
    logic [NR-1:0]     mirror_rank = '0;
    logic [NMR*AW-1:0] mr_values = '0;
    logic              cmd_valid;
    logic              cmd_ready = 1'b0;
    logic              cmd_zq, cmd_side, done;
    logic [RW-1:0]     cmd_rank;
    logic [1:0]        cmd_bg, cmd_ba;
    logic [AW-1:0]     cmd_addr;
    logic [IW-1:0]     cmd_idle;

    always #2 clk = ~clk;

    ddr4_rank_init_seq u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .rank_present(rank_present),
        .fast_rate(fast_rate), .zq_en(zq_en), .mirror_rank(mirror_rank),
        .mr_values(mr_values), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_zq(cmd_zq), .cmd_side(cmd_side), .cmd_rank(cmd_rank), .cmd_bg(cmd_bg),
        .cmd_ba(cmd_ba), .cmd_addr(cmd_addr), .cmd_idle(cmd_idle), .done(done)
    );

    int n_chk = 0;
    int n_err = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // expected stream
    logic [AW-1:0] e_addr [64];
    logic [1:0]    e_bg [64];
    logic [1:0]    e_ba [64];
    bit            e_zq [64];
    bit            e_side [64];
    bit            e_mir [64];
    int            e_rank [64];
    int            e_idle [64];
    int            n_exp;

    function automatic logic [21:0] model_word(input logic [17:0] a, input logic [1:0] bg,
                                               input logic [1:0] ba, input bit mir, input bit side);
        logic [17:0] r = a;
        logic [1:0]  g = bg;
        logic [1:0]  b = ba;
        if (mir) begin
            r[3] = a[4];  r[4] = a[3];
            r[5] = a[6];  r[6] = a[5];
            r[7] = a[8];  r[8] = a[7];
            r[11] = a[13]; r[13] = a[11];
            g = {bg[0], bg[1]};
            b = {ba[0], ba[1]};
        end
        if (side) begin
            for (int k = 0; k < 18; k++)
                if ((k >= 3 && k <= 9) || k == 11 || k == 13 || k == 17) r[k] = ~r[k];
            g = ~g;
            b = ~b;
        end
        return {g, b, r};
    endfunction

    task automatic add_cmd(input bit zq, input int rank, input bit side, input bit mir,
                           input logic [17:0] a, input logic [1:0] bg, input logic [1:0] ba, input int idle);
        logic [21:0] w;
        w = model_word(a, bg, ba, mir, side);
        e_zq[n_exp] = zq; e_rank[n_exp] = rank; e_side[n_exp] = side; e_mir[n_exp] = mir;
        e_bg[n_exp] = w[21:20]; e_ba[n_exp] = w[19:18]; e_addr[n_exp] = w[17:0];
        e_idle[n_exp] = idle;
        n_exp++;
    endtask

    task automatic build(input logic [NR-1:0] mask, input bit fast, input bit zq,
                         input logic [NR-1:0] mir, input logic [NMR*AW-1:0] mrv);
        n_exp = 0;
        for (int m = 0; m < NMR; m++)
            for (int r = 0; r < NR; r++)
                if (mask[r])
                    for (int s = 0; s < 2; s++)
                        add_cmd(1'b0, r, s[0], mir[r], mrv[m*AW +: AW], {1'b0, m[2]}, m[1:0], 8);
        if (zq)
            for (int r = 0; r < NR; r++)
                if (mask[r])
                    for (int s = 0; s < 2; s++)
                        add_cmd(1'b1, r, s[0], mir[r], 18'h00400, 2'b00, 2'b00, fast ? 1792 : 1621);
    endtask

    // monitor
    int cyc = 0, start_cyc = 0, last_hs = 0, got = 0, done_cnt = 0;
    bit arm = 0, seen_valid = 0, run_on = 0;
    bit pv = 0, pr = 0, pside = 0;
    logic [AW-1:0] paddr = '0;
    logic [RW-1:0] prank = '0;

    always @(negedge clk) begin
        cyc++;
        if (start && arm) begin
            start_cyc = cyc;
            arm = 0;
        end
        if (run_on) begin
            if (pv && !pr)
                chk(cmd_valid && cmd_addr == paddr && cmd_side == pside && cmd_rank == prank,
                    "R9 hold", {cmd_valid, cmd_addr}, {1'b1, paddr});
            if (cmd_valid && !seen_valid) begin
                seen_valid = 1;
                if (got == 0)
                    chk(cyc - start_cyc == 1, "R8 first command timing", cyc - start_cyc, 1);
                else if (got <= n_exp)
                    chk(cyc - last_hs == e_idle[got-1] + 1, "R8 idle gap", cyc - last_hs, e_idle[got-1] + 1);
            end
            if (cmd_valid && cmd_ready) begin
                if (got < n_exp) begin
                    chk(cmd_zq == e_zq[got] && int'(cmd_rank) == e_rank[got] && cmd_side == e_side[got],
                        e_zq[got] ? "R4 order/type" : "R2 order/type",
                        {cmd_zq, cmd_rank, cmd_side}, {e_zq[got], 2'(e_rank[got]), e_side[got]});
                    chk(cmd_addr == e_addr[got] && cmd_bg == e_bg[got] && cmd_ba == e_ba[got],
                        e_side[got] ? "R6 B-side word" : (e_mir[got] ? "R7 mirrored word" :
                                                        (e_zq[got] ? "R4 ZQ word" : "R3 mode word")),
                        {cmd_bg, cmd_ba, cmd_addr}, {e_bg[got], e_ba[got], e_addr[got]});
                    chk(int'(cmd_idle) == e_idle[got], e_zq[got] ? "R5 ZQ idle" : "R3 mode idle",
                        cmd_idle, e_idle[got]);
                end else begin
                    chk(1'b0, "R2 extra command", got, n_exp);
                end
                got++;
                last_hs = cyc;
                seen_valid = 0;
            end
            if (done) begin
                done_cnt++;
                chk(got == n_exp, "R10 commands before done", got, n_exp);
                if (n_exp == 0)
                    chk(cyc - start_cyc == 1, "R10 empty-mask done timing", cyc - start_cyc, 1);
                else
                    chk(cyc - last_hs == e_idle[n_exp-1] + 1, "R10 done timing",
                        cyc - last_hs, e_idle[n_exp-1] + 1);
            end
        end
        pv = cmd_valid; pr = cmd_ready; pside = cmd_side; paddr = cmd_addr; prank = cmd_rank;
    end

    always @(posedge clk) begin
        #1 cmd_ready <= ($urandom % 4) != 0;
    end

    task automatic pulse_start();
        @(posedge clk); #1 start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
    endtask

    task automatic run_case(input logic [NR-1:0] mask, input bit fast, input bit zq,
                            input logic [NR-1:0] mir, input bit poke);
        logic [NMR*AW-1:0] mrv;
        int waited;
        for (int m = 0; m < NMR; m++) mrv[m*AW +: AW] = AW'($urandom);
        build(mask, fast, zq, mir, mrv);
        @(posedge clk); #1;
        rank_present = mask; fast_rate = fast; zq_en = zq; mirror_rank = mir; mr_values = mrv;
        got = 0; done_cnt = 0; seen_valid = 0; arm = 1; run_on = 1;
        pulse_start();
        if (poke) begin
            // R11: restart and reconfigure mid-run
            repeat (25) @(posedge clk);
            #1;
            rank_present = ~mask; zq_en = ~zq; fast_rate = ~fast; mirror_rank = ~mir;
            mr_values = ~mrv;
            start = 1'b1;
            @(posedge clk); #1 start = 1'b0;
        end
        waited = 0;
        while (done_cnt == 0 && waited < 30000) begin
            @(posedge clk);
            waited++;
        end
        if (done_cnt == 0) chk(1'b0, "R10 done never seen", 0, 1);
        repeat (6) @(posedge clk);
        chk(done_cnt == 1, "R11 single done per run", done_cnt, 1);
        chk(got == n_exp, "R2 command count", got, n_exp);
        run_on = 0;
    endtask

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(!cmd_valid, "R1 reset valid", cmd_valid, 0);
        chk(!done, "R1 reset done", done, 0);
        repeat (5) @(negedge clk);
        chk(!cmd_valid && !done, "R1 idle without start", {cmd_valid, done}, 0);

        run_case(4'b1111, 1'b1, 1'b1, 4'b1010, 1'b0);   // R5 fast, R7 mirror
        run_case(4'b0000, 1'b0, 1'b1, 4'b0000, 1'b0);   // R10 empty mask
        run_case(4'b0101, 1'b0, 1'b0, 4'b0001, 1'b0);   // R4 ZQ off
        run_case(4'b1000, 1'b0, 1'b1, 4'b1000, 1'b1);   // R5 slow, R11 restart
        run_case(4'b0010, 1'b1, 1'b0, 4'b0000, 1'b1);   // R11 restart in MRS phase
        for (int t = 0; t < 5; t++) begin
            logic [NR-1:0] mk;
            mk = NR'($urandom);
            run_case(mk, 1'($urandom), 1'($urandom), NR'($urandom), (mk != 0) && 1'($urandom));
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule